// File: doc/BRIEF.md
# Light-Level Window Interrupt with Persistence Filter

This block watches the stream of finished light conversions and raises an interrupt when the readings leave a programmable band. Each time the converter finishes, it presents a 16-bit result together with a one-cycle done strobe. The block compares that result against a 16-bit lower bound and a 16-bit upper bound. A result counts only if it falls strictly outside the band.

A single excursion does not fire the interrupt. The block counts how many finished results in a row fell outside the band. It fires only when that run reaches a length chosen by a 2-bit persistence code. When it fires, a status flag goes high and an active-low interrupt pin goes low. Both stay there until the bus interface reports that the status register has been read, which it does with a one-cycle clear pulse.

A power-down input forgets any run in progress. The register bank around the block holds the two bounds, with a lower bound of 0000h and an upper bound of FFFFh after reset. With those values no 16-bit result can ever trigger.

Top module: `winIntPersist`

## Requirements
- R1: A finished result is outside the band only when `convData < thrLow` or `convData > thrHigh`. A result equal to either bound is inside the band.
- R2: The persistence code on `persistSel` selects the run length that fires: 2'b00 needs 1 result, 2'b01 needs 4, 2'b10 needs 8 and 2'b11 needs 16 consecutive outside results.
- R3: Any finished result inside the band resets the run count to zero, so a broken run must start again from one.
- R4: When the run reaches the selected length, `statusFlag` is high and `irqN` is low from the clock edge that takes that result onward. `irqN` is always the complement of `statusFlag`.
- R5: Once set, the flag and the pin hold their state until a `clearReq` pulse. The edge that takes the pulse drops the flag, unless R6 applies.
- R6: If a `clearReq` and a firing result are taken at the same edge, the flag stays set.
- R7: The run count saturates at 16. While the run goes on, every further outside result fires again, so a clear taken mid-run is followed by a new fire at the next outside result.
- R8: While `powerDown` is high, the run count is held at zero and done strobes have no effect on the count or the flag. The flag keeps its value.
- R9: After reset the flag is low, `irqN` is high and the run count is zero. With the bounds at their after-reset values of 0000h and FFFFh, no result ever fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| convDone | input | 1 | One-cycle strobe: a conversion result is valid |
| convData | input | 16 | Conversion result |
| thrLow | input | 16 | Lower bound of the band |
| thrHigh | input | 16 | Upper bound of the band |
| persistSel | input | 2 | Persistence code (1, 4, 8 or 16 results) |
| powerDown | input | 1 | Sensor powered down; resets the run |
| clearReq | input | 1 | One-cycle pulse when the status register is read |
| statusFlag | output | 1 | Latched interrupt status, active high |
| irqN | output | 1 | Interrupt pin, active low |

## Verification
The bench sweeps every persistence code against every run length from 1 to 18. A design with an off-by-one in the run length would fire one result early or late somewhere in that sweep. Each bound is probed at itself and at one step beyond. A non-strict compare would fire on a value equal to a bound, and a compare with the bounds swapped would miss a value one past them.

Several cases target the latch and the counter. A run is broken by an inside result and then resumed, which exposes a counter that is not cleared. A clear arrives in the same cycle as a fire, which exposes a wrong priority. A long run is continued past sixteen with clears in between, which exposes a counter that wraps instead of saturating. Power-down is applied in the middle of a run, which exposes a run that survives the power-down or done strobes that are not ignored.

// File: rtl/win_int_pkg.sv
package win_int_pkg;
  localparam int DATA_W      = 16;
  localparam int MAX_PERSIST = 16;
  localparam int CNT_W       = $clog2(MAX_PERSIST + 1);

  typedef struct packed {
    logic cntInc;
    logic cntZero;
    logic flagSet;
    logic flagClr;
  } ctrlStrobes_t;
endpackage

// File: rtl/win_int_datapath.sv
module win_int_datapath
  import win_int_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int MAXC = MAX_PERSIST,
  localparam int CW  = $clog2(MAXC + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] convData,
  input  logic [DW-1:0] thrLow,
  input  logic [DW-1:0] thrHigh,
  input  ctrlStrobes_t  strobes,
  output logic          outOfWindow,
  output logic [CW-1:0] runCount
);
  logic belowLow;
  logic aboveHigh;
  logic atCeiling;

  // Both compares are strict: a result equal to a bound stays inside the band.
  assign belowLow    = convData < thrLow;
  assign aboveHigh   = convData > thrHigh;
  assign outOfWindow = belowLow | aboveHigh;
  assign atCeiling   = (runCount == CW'(MAXC));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCount <= '0;
    end else if (strobes.cntZero) begin
      runCount <= '0;
    end else if (strobes.cntInc && !atCeiling) begin
      runCount <= runCount + 1'b1;
    end
  end
endmodule

// File: rtl/win_int_control.sv
module win_int_control
  import win_int_pkg::*;
#(
  parameter int MAXC = MAX_PERSIST,
  localparam int CW  = $clog2(MAXC + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          convDone,
  input  logic          powerDown,
  input  logic          clearReq,
  input  logic          outOfWindow,
  input  logic [CW-1:0] runCount,
  input  logic [1:0]    persistSel,
  output ctrlStrobes_t  strobes,
  output logic          statusFlag
);
  logic [CW:0] needed;
  logic [CW:0] nextRun;
  logic        liveDone;

  // Persistence code to run length: 00 -> 1, 01 -> 4, 10 -> 8, 11 -> 16.
  always_comb begin
    if (persistSel == 2'b00) needed = (CW+1)'(1);
    else                     needed = (CW+1)'(4) << (persistSel - 2'd1);
  end

  assign liveDone = convDone && !powerDown;
  assign nextRun  = {1'b0, runCount} + 1'b1;

  always_comb begin
    strobes.cntZero = powerDown || (liveDone && !outOfWindow);
    strobes.cntInc  = liveDone && outOfWindow;
    strobes.flagSet = liveDone && outOfWindow && (nextRun >= needed);
    strobes.flagClr = clearReq;
  end

  // A fire taken at the same edge as a clear keeps the flag set.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                statusFlag <= 1'b0;
    else if (strobes.flagSet) statusFlag <= 1'b1;
    else if (strobes.flagClr) statusFlag <= 1'b0;
  end
endmodule

// File: rtl/winIntPersist.sv
module winIntPersist
  import win_int_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convData,
  input  logic [DATA_W-1:0] thrLow,
  input  logic [DATA_W-1:0] thrHigh,
  input  logic [1:0]        persistSel,
  input  logic              powerDown,
  input  logic              clearReq,
  output logic              statusFlag,
  output logic              irqN
);
  ctrlStrobes_t     strobes;
  logic             outOfWindow;
  logic [CNT_W-1:0] persistCount;

  win_int_datapath #(.DW(DATA_W), .MAXC(MAX_PERSIST)) uDatapath (
    .clk        (clk),
    .rstN       (rstN),
    .convData   (convData),
    .thrLow     (thrLow),
    .thrHigh    (thrHigh),
    .strobes    (strobes),
    .outOfWindow(outOfWindow),
    .runCount   (persistCount)
  );

  win_int_control #(.MAXC(MAX_PERSIST)) uControl (
    .clk        (clk),
    .rstN       (rstN),
    .convDone   (convDone),
    .powerDown  (powerDown),
    .clearReq   (clearReq),
    .outOfWindow(outOfWindow),
    .runCount   (persistCount),
    .persistSel (persistSel),
    .strobes    (strobes),
    .statusFlag (statusFlag)
  );

  assign irqN = ~statusFlag;
endmodule

// File: rtl/winIntPersist_checker.sv
module winIntPersist_checker
  import win_int_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              convDone,
  input logic [DATA_W-1:0] convData,
  input logic [DATA_W-1:0] thrLow,
  input logic [DATA_W-1:0] thrHigh,
  input logic [1:0]        persistSel,
  input logic              powerDown,
  input logic              clearReq,
  input logic              statusFlag,
  input logic              irqN,
  input logic [CNT_W-1:0]  persistCount
);
  logic portOutside;
  assign portOutside = (convData < thrLow) || (convData > thrHigh);

  assert_pin_mirrors_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    irqN == !statusFlag);

  assert_inside_zeroes_run_R3: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && !powerDown && !portOutside) |=> persistCount == '0);

  assert_powerdown_zeroes_run_R8: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> persistCount == '0);

  assert_run_saturates_R7: assert property (@(posedge clk) disable iff (!rstN)
    persistCount <= CNT_W'(MAX_PERSIST));

  assert_fall_needs_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusFlag) |-> $past(clearReq));

  assert_rise_needs_result_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusFlag) |-> $past(convDone && !powerDown && portOutside));

  assert_single_fire_beats_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (persistSel == 2'b00 && convDone && !powerDown && portOutside) |=> statusFlag);
endmodule

bind winIntPersist winIntPersist_checker uChecker (
  .clk         (clk),
  .rstN        (rstN),
  .convDone    (convDone),
  .convData    (convData),
  .thrLow      (thrLow),
  .thrHigh     (thrHigh),
  .persistSel  (persistSel),
  .powerDown   (powerDown),
  .clearReq    (clearReq),
  .statusFlag  (statusFlag),
  .irqN        (irqN),
  .persistCount(persistCount)
);

// File: tb/winIntPersist_test.sv
module winIntPersist_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        convDone = 1'b0;
  logic [15:0] convData = '0;
  logic [15:0] thrLow = 16'h0000;
  logic [15:0] thrHigh = 16'hFFFF;
  logic [1:0]  persistSel = 2'b00;
  logic        powerDown = 1'b0;
  logic        clearReq = 1'b0;
  logic        statusFlag;
  logic        irqN;

  int vectors = 0;
  int errors  = 0;
  int modelRun = 0;
  bit modelFlag = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  winIntPersist uut (
    .clk(clk), .rstN(rstN), .convDone(convDone), .convData(convData),
    .thrLow(thrLow), .thrHigh(thrHigh), .persistSel(persistSel),
    .powerDown(powerDown), .clearReq(clearReq),
    .statusFlag(statusFlag), .irqN(irqN)
  );

  function automatic int needFor(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 16;
    endcase
  endfunction

  task automatic check(input string req);
    vectors++;
    if (statusFlag !== modelFlag || irqN !== !modelFlag) begin
      errors++;
      $display("FAIL %s: flag=%0b irqN=%0b expected flag=%0b irqN=%0b",
               req, statusFlag, irqN, modelFlag, !modelFlag);
    end
  endtask

  // Called at a negedge: drives one cycle of inputs, advances the model, checks at the next negedge.
  task automatic step(input bit cd, input logic [15:0] d, input bit clr, input bit pd, input string req);
    bit trig = 0;
    convDone = cd; convData = d; clearReq = clr; powerDown = pd;
    if (pd) modelRun = 0;
    else if (cd) begin
      if (d < thrLow || d > thrHigh) begin
        modelRun = (modelRun + 1 > 16) ? 16 : modelRun + 1;
        trig = (modelRun >= needFor(persistSel));
      end else modelRun = 0;
    end
    if (trig) modelFlag = 1;
    else if (clr) modelFlag = 0;
    @(negedge clk);
    convDone = 0; clearReq = 0;
    check(req);
  endtask

  task automatic resetAll();
    step(0, 0, 1, 1, "R5 reset run");
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset state");
    rstN = 1'b1;
    @(negedge clk);
    check("R9 after release");

    // R9: after-reset bounds never fire, sweep the whole data range coarsely plus extremes
    for (int v = 0; v < 65536; v += 257) step(1, 16'(v), 0, 0, "R9 default bounds");
    step(1, 16'hFFFF, 0, 0, "R9 default bounds max");
    step(1, 16'h0000, 0, 0, "R9 default bounds min");

    thrLow = 16'h1000; thrHigh = 16'h8000;

    // R1: strict compare at each bound, single-result persistence
    persistSel = 2'b00;
    for (int k = 0; k < 6; k++) begin
      logic [15:0] probe;
      case (k)
        0: probe = 16'h1000; 1: probe = 16'h8000; 2: probe = 16'h0FFF;
        3: probe = 16'h8001; 4: probe = 16'h0000; default: probe = 16'hFFFF;
      endcase
      resetAll();
      step(1, probe, 0, 0, "R1 bound probe");
    end

    // R2/R4: every code against every run length
    for (int code = 0; code < 4; code++) begin
      persistSel = 2'(code);
      for (int len = 1; len <= 18; len++) begin
        resetAll();
        step(1, 16'h4000, 0, 0, "R3 start inside");
        for (int i = 0; i < len; i++)
          step(1, (i % 2) ? 16'h0100 : 16'hF000, 0, 0, "R2 run length");
        // idle cycles: flag must hold (R5)
        step(0, 16'h4000, 0, 0, "R5 hold idle");
      end
    end

    // R3: broken run restarts
    persistSel = 2'b01;
    resetAll();
    for (int i = 0; i < 3; i++) step(1, 16'hF000, 0, 0, "R3 pre-break");
    step(1, 16'h1000, 0, 0, "R3 break on bound");
    for (int i = 0; i < 4; i++) step(1, 16'hF000, 0, 0, "R3 restart run");

    // R6: clear and fire in the same cycle
    persistSel = 2'b00;
    resetAll();
    step(1, 16'hF000, 0, 0, "R4 fire");
    step(1, 16'hF000, 1, 0, "R6 clear vs fire");
    step(0, 0, 1, 0, "R5 clear alone");
    step(1, 16'h2000, 1, 0, "R5 clear with inside result");

    // R7: long run at code 11, clears mid-run refire
    persistSel = 2'b11;
    resetAll();
    for (int i = 0; i < 20; i++) step(1, 16'h0001, 0, 0, "R7 long run");
    for (int i = 0; i < 5; i++) begin
      step(0, 0, 1, 0, "R7 clear mid-run");
      step(1, 16'h0001, 0, 0, "R7 refire after saturation");
    end

    // R8: power-down erases run and ignores strobes
    persistSel = 2'b01;
    resetAll();
    for (int i = 0; i < 3; i++) step(1, 16'hF000, 0, 0, "R8 pre powerdown");
    step(1, 16'hF000, 0, 1, "R8 strobe during powerdown");
    step(1, 16'hF000, 0, 1, "R8 strobe during powerdown");
    for (int i = 0; i < 4; i++) step(1, 16'hF000, 0, 0, "R8 run after powerdown");
    step(1, 16'hF000, 0, 1, "R8 flag kept in powerdown");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule